// File: doc/BRIEF.md
# Diagonal-Accumulation Matrix Multiplier

This block multiplies two square N×N matrices, C = A·B, on a two-dimensional grid of multiply-add cells. Work item (i, j, k) adds the product A[i][k]·B[k][j] to a running sum. It runs on grid cell (i+k, j+k) at step i+j+k, counted from the first step of the run. Values of A travel one cell per cycle along the grid's column axis, and values of B travel one cell per cycle along its row axis. Each running sum of C moves one cell down and one cell right every cycle, so the accumulators flow diagonally instead of staying in one cell. A sum is complete once it leaves the cell where k = N−1.

A one-cycle start pulse, given while the block is idle, captures both matrices into internal buffers. A feeder then drives the grid's left column with A values and its top row with B values. Each value arrives on exactly the step its schedule requires, and the feeder drives zero at every other time. A separate output lane for each row of C presents one finished element per cycle, tagged with its row and column. The done flag marks the last busy cycle. A new start can follow immediately, because the zeros fed in drain the grid by the end of every run.

Top module: `mm_diag_array`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, busy, done and every res_valid bit are 0, even with start held high.
- R2: A start pulse seen while busy is 0 sets busy from the next cycle. Busy then stays high for exactly 3N−1 cycles. Without a start, the block stays idle.
- R3: Each result equals the unsigned sum over k of A[i][k]·B[k][j] at full precision, using CW = 2·DW + clog2(N) bits. Element (i,k) of A sits at bits (i·N+k)·DW of a_mat, and element (k,j) of B sits at bits (k·N+j)·DW of b_mat.
- R4: Counting the edge that accepts start as edge 1, result (i,j) is valid on lane i in the cycle that follows edge i+j+N+1. It is valid in no other cycle.
- R5: Lane r carries row r in res_row[r·IW +: IW], the column in res_col[r·IW +: IW] and the value in res_data[r·CW +: CW]. Each lane is valid for exactly N consecutive cycles, with columns 0 to N−1 in ascending order.
- R6: Done is high for exactly one cycle per run. That cycle is the last busy cycle, and lane N−1 shows column N−1 in it. Busy is 0 in the following cycle.
- R7: A start in the first idle cycle after done is accepted. Each run's results are independent of the run before it, because the grid holds only zeros whenever busy is 0.
- R8: While busy is 1, both start and any change on a_mat or b_mat have no effect on the timing or the values of the results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a multiplication when idle |
| a_mat | input | N·N·DW | Matrix A, row-major, unsigned |
| b_mat | input | N·N·DW | Matrix B, row-major, unsigned |
| busy | output | 1 | High while a run is in progress |
| done | output | 1 | High in the last busy cycle |
| res_valid | output | N | One valid bit per row lane |
| res_row | output | N·IW | Row index for each lane |
| res_col | output | N·IW | Column index for each lane |
| res_data | output | N·CW | Result value for each lane |

## Verification
The assertions assume that N is at least 2, that rst_n is low at time zero, and that start is driven to a known level at every clock edge. The drain check also assumes that the grid registers start from reset, so that only zeros enter while the block is idle. The stimulus holds reset from time zero and drives start and both matrices on falling edges only. Inside a run it deliberately pulses start again and inverts both matrices, which keeps within these assumptions while exercising the rule that such inputs are ignored.

// File: rtl/mm_diag_array.sv
module mm_diag_array #(
  parameter int N  = 4,
  parameter int DW = 8,
  localparam int IW = $clog2(N),
  localparam int CW = 2 * DW + $clog2(N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [N*N*DW-1:0] a_mat,
  input  logic [N*N*DW-1:0] b_mat,
  output logic              busy,
  output logic              done,
  output logic [N-1:0]      res_valid,
  output logic [N*IW-1:0]   res_row,
  output logic [N*IW-1:0]   res_col,
  output logic [N*CW-1:0]   res_data
);
  localparam int G    = 2 * N - 1;
  localparam int LAST = 3 * N - 2;
  localparam int CNTW = $clog2(LAST + 1);

  logic [CNTW-1:0] cnt;
  logic [DW-1:0]   am [N*N];
  logic [DW-1:0]   bm [N*N];
  logic [DW-1:0]   a_edge [G];
  logic [DW-1:0]   b_edge [G];
  logic [DW-1:0]   a_in [G][G];
  logic [DW-1:0]   b_in [G][G];
  logic [DW-1:0]   a_r  [G][G];
  logic [DW-1:0]   b_r  [G][G];
  logic [CW-1:0]   c_in [G][G];
  logic [CW-1:0]   c_r  [G][G];
  logic            residue;

  assign done = busy && (cnt == CNTW'(LAST));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1;
        cnt  <= '0;
      end
    end else if (done) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < N * N; e++) begin
        am[e] <= '0;
        bm[e] <= '0;
      end
    end else if (!busy && start) begin
      for (int e = 0; e < N * N; e++) begin
        am[e] <= a_mat[e*DW +: DW];
        bm[e] <= b_mat[e*DW +: DW];
      end
    end
  end

  // Skew feeder: A[i][u-i] enters row u at step i, B[v-j][j] enters column v at step j.
  always_comb begin
    for (int u = 0; u < G; u++) begin
      a_edge[u] = '0;
      b_edge[u] = '0;
      for (int s = 0; s < N; s++) begin
        if (busy && cnt == CNTW'(s) && u >= s && u - s < N) begin
          a_edge[u] = am[(u >= s && u - s < N) ? s * N + u - s : 0];
          b_edge[u] = bm[(u >= s && u - s < N) ? (u - s) * N + s : 0];
        end
      end
    end
  end

  for (genvar gu = 0; gu < G; gu++) begin : g_row
    for (genvar gv = 0; gv < G; gv++) begin : g_col
      if (gv == 0) begin : g_aw
        assign a_in[gu][gv] = a_edge[gu];
      end else begin : g_ai
        assign a_in[gu][gv] = a_r[gu][gv-1];
      end
      if (gu == 0) begin : g_bn
        assign b_in[gu][gv] = b_edge[gv];
      end else begin : g_bi
        assign b_in[gu][gv] = b_r[gu-1][gv];
      end
      if (gu == 0 || gv == 0) begin : g_cz
        assign c_in[gu][gv] = '0;
      end else begin : g_cd
        assign c_in[gu][gv] = c_r[gu-1][gv-1];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          a_r[gu][gv] <= '0;
          b_r[gu][gv] <= '0;
          c_r[gu][gv] <= '0;
        end else begin
          a_r[gu][gv] <= a_in[gu][gv];
          b_r[gu][gv] <= b_in[gu][gv];
          c_r[gu][gv] <= c_in[gu][gv] + CW'(a_in[gu][gv]) * CW'(b_in[gu][gv]);
        end
      end
    end
  end

  // Row r finishes column j in cell (r+N-1, j+N-1) at step r+j+N-1.
  always_comb begin
    res_valid = '0;
    res_row   = '0;
    res_col   = '0;
    res_data  = '0;
    for (int r = 0; r < N; r++) begin
      for (int j = 0; j < N; j++) begin
        if (busy && cnt == CNTW'(N + r + j)) begin
          res_valid[r]          = 1'b1;
          res_row[r*IW +: IW]   = IW'(r);
          res_col[r*IW +: IW]   = IW'(j);
          res_data[r*CW +: CW]  = c_r[r+N-1][j+N-1];
        end
      end
    end
  end

  always_comb begin
    residue = 1'b0;
    for (int u = 0; u < G; u++) begin
      for (int v = 0; v < G; v++) begin
        residue = residue | (a_r[u][v] != '0) | (b_r[u][v] != '0) | (c_r[u][v] != '0);
      end
    end
  end

  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n |=> (!busy && !done && res_valid == '0));

  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && cnt == '0));

  p_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> (busy && cnt == CNTW'($past(cnt) + 1'b1)));

  p_done_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  p_done_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (res_valid[N-1] && res_col[(N-1)*IW +: IW] == IW'(N - 1)));

  p_valid_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid != '0) |-> busy);

  p_drained_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !residue);

  for (genvar gr = 0; gr < N; gr++) begin : g_lane_chk
    p_first_col_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(res_valid[gr]) |-> res_col[gr*IW +: IW] == '0);
    p_col_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid[gr] && $past(res_valid[gr])) |->
        res_col[gr*IW +: IW] == IW'($past(res_col[gr*IW +: IW]) + 1'b1));
  end
endmodule

// File: tb/mm_diag_array_test.sv
module mm_diag_array_test;
  localparam int PERIOD = 10;
  localparam int N  = 4;
  localparam int DW = 8;
  localparam int IW = $clog2(N);
  localparam int CW = 2 * DW + $clog2(N);
  localparam int MW = N * N * DW;
  localparam int NC = 5;

  localparam logic [MW-1:0] ID   = 128'h01000000_00010000_00000100_00000001;
  localparam logic [MW-1:0] RAMP = 128'h0f0e0d0c_0b0a0908_07060504_03020100;
  localparam logic [MW-1:0] MIXA = 128'h01234567_89abcdef_fedcba98_76543210;
  localparam logic [MW-1:0] MIXB = 128'h11223344_55667788_99aabbcc_ddeeff00;
  localparam logic [MW-1:0] FULL = {16{8'hff}};

  localparam logic [MW-1:0] A_TAB [NC] = '{ID, RAMP, FULL, MIXA, '0};
  localparam logic [MW-1:0] B_TAB [NC] = '{RAMP, ID, FULL, MIXB, MIXA};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [MW-1:0] a_mat = '0;
  logic [MW-1:0] b_mat = '0;
  logic          busy, done;
  logic [N-1:0]  res_valid;
  logic [N*IW-1:0] res_row, res_col;
  logic [N*CW-1:0] res_data;

  int n_checks = 0;
  int n_errs = 0;

  mm_diag_array #(.N(N), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .a_mat(a_mat), .b_mat(b_mat),
    .busy(busy), .done(done), .res_valid(res_valid), .res_row(res_row),
    .res_col(res_col), .res_data(res_data)
  );

  always #(PERIOD / 2) clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic longint ref_c(input logic [MW-1:0] a, input logic [MW-1:0] b,
                                   input int i, input int j);
    longint s = 0;
    for (int k = 0; k < N; k++)
      s += longint'(a[(i*N+k)*DW +: DW]) * longint'(b[(k*N+j)*DW +: DW]);
    return s;
  endfunction

  // Called just after a falling edge; returns at the falling edge of the first idle cycle.
  task automatic run_case(input logic [MW-1:0] a, input logic [MW-1:0] b,
                          input bit disturb, input string dtag);
    a_mat = a;
    b_mat = b;
    start = 1'b1;
    @(posedge clk);
    for (int c = 1; c <= 3 * N; c++) begin
      @(negedge clk);
      start = disturb && c >= 2 && c <= 4;
      if (disturb && c == 2) begin
        a_mat = ~a;
        b_mat = ~b;
      end
      check(busy == (c <= 3 * N - 1), (c == 1) ? "R7" : "R2", longint'(busy), longint'(c <= 3 * N - 1));
      check(done == (c == 3 * N - 1), "R6", longint'(done), longint'(c == 3 * N - 1));
      for (int r = 0; r < N; r++) begin
        int  j;
        bit  ev;
        j  = c - N - 1 - r;
        ev = (j >= 0 && j < N);
        check(res_valid[r] == ev, "R4", longint'(res_valid[r]), longint'(ev));
        if (ev) begin
          check(res_row[r*IW +: IW] == IW'(r), "R5", longint'(res_row[r*IW +: IW]), longint'(r));
          check(res_col[r*IW +: IW] == IW'(j), "R5", longint'(res_col[r*IW +: IW]), longint'(j));
          check(longint'(res_data[r*CW +: CW]) == ref_c(a, b, r, j), dtag,
                longint'(res_data[r*CW +: CW]), ref_c(a, b, r, j));
        end
      end
    end
    start = 1'b0;
  endtask

  initial begin
    #(PERIOD * 20000);
    n_checks++;
    n_errs++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

  initial begin
    // R1: reset holds the block idle even with start high
    start = 1'b1;
    a_mat = RAMP;
    b_mat = RAMP;
    repeat (3) @(negedge clk);
    check(!busy && !done, "R1", longint'({busy, done}), 0);
    check(res_valid == '0, "R1", longint'(res_valid), 0);
    start = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && res_valid == '0, "R1", longint'(busy), 0);

    // R2: no start, no run
    repeat (4) @(negedge clk);
    check(!busy && !done, "R2", longint'({busy, done}), 0);

    // Table walk; every entry after the first starts in the first idle cycle (R7)
    for (int t = 0; t < NC; t++)
      run_case(A_TAB[t], B_TAB[t], 1'b0, "R3");

    // R7: an all-zero run right after the largest values must show no residue
    run_case(FULL, FULL, 1'b0, "R3");
    run_case('0, '0, 1'b0, "R7");

    // R8: start pulses and matrix changes during a run are ignored
    run_case(MIXA, MIXB, 1'b1, "R8");

    repeat (3) @(negedge clk);
    check(!busy && res_valid == '0, "R8", longint'(busy), 0);

    $display("  Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule